// File: doc/BRIEF.md
# Machine-Level Control Register File with Cycle and Retire Counters

This block holds the machine-level control and status registers of a 32-bit core: a status word, an interrupt-enable word, a trap vector, a scratch word, an exception PC, an exception cause and a counter-inhibit word. It also holds two 64-bit event counters, one for clock cycles and one for retired instructions. Software reaches each counter as a low and a high 32-bit half. Four constant identification words and two always-zero words complete the address map.

Each cycle the pipeline presents at most one access: a 12-bit register number on a wider address bus, an operation code, an operand and the current privilege level. The block answers in the same cycle with the register's old value or an illegal flag. A write takes effect at the next clock edge. Requests need no handshake. The block takes one access every cycle and never stalls, so the request side has no back-pressure. The retire strobe is a plain control input.

In a given cycle, a software write to a counter half takes priority over that half's increment. The other half still takes the incremented value. Writing zero to the cycle counter and reading it after N idle cycles therefore returns exactly N.

Top module: `mcsr_file`

## Requirements
- R1: While `req_valid` is high, `rsp_illegal` is high in the same cycle if `req_addr` is 4096 or more, if `req_addr[9:8]` exceeds `cur_priv`, or if the low 12 bits name no register in the map. In that cycle `rsp_rdata` is zero.
- R2: A rejected access leaves every register and counter half unchanged, except for the normal counter increments.
- R3: `req_op` encodings are 0 read, 1 write, 2 set and 3 clear. Set stores old OR operand. Clear stores old AND NOT operand. Every legal access returns the old value on `rsp_rdata` in its own cycle. The new value is visible from the next cycle.
- R4: The value stored is masked. The trap vector uses 0xFFFFFFFD, the exception PC uses 0xFFFFFFFE, the exception cause uses 0x8000000F and counter-inhibit uses 0x7. Status, interrupt-enable and scratch keep all 32 bits.
- R5: Addresses 0x301 (ISA word), 0xF12 (architecture id), 0xF13 (implementation id) and 0xF14 (hart id) read their parameter values, and 0x343 and 0x344 read zero. Writes to any of these six are accepted without the illegal flag and change nothing.
- R6: The cycle counter (low half 0xB00, high half 0xB80) advances by one on every clock unless counter-inhibit bit 0 is set. A carry out of the low half increments the high half.
- R7: The retire counter (low half 0xB02, high half 0xB82) advances by one on each clock with `retire` high, unless counter-inhibit bit 2 is set.
- R8: A write to a counter half overrides that half's increment in the same cycle. After a write of zero to 0xB00 and eight idle cycles, a read of 0xB00 returns 8.
- R9: Reset (`rst_n` low, synchronous) clears all seven writable registers and both counters.
- R10: The writable registers are status at 0x300, interrupt-enable at 0x304, trap vector at 0x305, counter-inhibit at 0x320, scratch at 0x340, exception PC at 0x341 and exception cause at 0x342. A change to counter-inhibit takes effect from the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| req_addr | input | AW (16) | Register number; values of 4096 and above are illegal |
| req_wdata | input | 32 | Write operand or bit mask |
| cur_priv | input | 2 | Privilege level of the requester (3 = machine) |
| retire | input | 1 | One instruction retires this cycle |
| rsp_rdata | output | 32 | Old value of the addressed register, zero when illegal |
| rsp_illegal | output | 1 | Access rejected |

## Verification
The bench sweeps all 4096 register numbers at every privilege level. A decoder that let a lower privilege through, or that aliased an address of 4096 or more onto its low 12 bits, would return data instead of the flag. Write-over-increment is exercised on both counter halves and with the zero-then-eight-cycles read. A design that applied the increment after the write would read 101 or 9 instead of 100 or 8. A low half parked at 0xFFFFFFFF under inhibit is released to catch a missing carry into the high half. Set and clear are checked against the masked registers, and the bench confirms that the returned value is the old one rather than the new one.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN   = 32;
  localparam int CSR_AW = 12;
  localparam int NPLAIN = 7;
  localparam int NCNT   = 2;
  localparam int IDX_W  = 3;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_PLAIN = 2'd1,
    K_COUNT = 2'd2,
    K_CONST = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
    logic             hi;
  } sel_t;

  // writable register slots
  localparam int P_STATUS  = 0;
  localparam int P_IRQEN   = 1;
  localparam int P_TVEC    = 2;
  localparam int P_SCRATCH = 3;
  localparam int P_EPC     = 4;
  localparam int P_CAUSE   = 5;
  localparam int P_INHIBIT = 6;

  // counters and their inhibit bits
  localparam int C_CYCLE     = 0;
  localparam int C_RETIRED   = 1;
  localparam int INH_CYC_BIT = 0;
  localparam int INH_RET_BIT = 2;

  // constant words
  localparam int Q_ISA  = 0;
  localparam int Q_ARCH = 1;
  localparam int Q_IMPL = 2;
  localparam int Q_HART = 3;
  localparam int Q_ZERO = 4;

  function automatic word_t plain_mask(input int slot);
    case (slot)
      P_TVEC:    return 32'hFFFF_FFFD;
      P_EPC:     return 32'hFFFF_FFFE;
      P_CAUSE:   return 32'h8000_000F;
      P_INHIBIT: return 32'h0000_0007;
      default:   return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic sel_t csr_decode(input logic [CSR_AW-1:0] a);
    sel_t s;
    s.kind = K_NONE;
    s.idx  = '0;
    s.hi   = 1'b0;
    case (a)
      12'h300: begin s.kind = K_PLAIN; s.idx = IDX_W'(P_STATUS);  end
      12'h304: begin s.kind = K_PLAIN; s.idx = IDX_W'(P_IRQEN);   end
      12'h305: begin s.kind = K_PLAIN; s.idx = IDX_W'(P_TVEC);    end
      12'h320: begin s.kind = K_PLAIN; s.idx = IDX_W'(P_INHIBIT); end
      12'h340: begin s.kind = K_PLAIN; s.idx = IDX_W'(P_SCRATCH); end
      12'h341: begin s.kind = K_PLAIN; s.idx = IDX_W'(P_EPC);     end
      12'h342: begin s.kind = K_PLAIN; s.idx = IDX_W'(P_CAUSE);   end
      12'hB00: begin s.kind = K_COUNT; s.idx = IDX_W'(C_CYCLE);   end
      12'hB80: begin s.kind = K_COUNT; s.idx = IDX_W'(C_CYCLE);   s.hi = 1'b1; end
      12'hB02: begin s.kind = K_COUNT; s.idx = IDX_W'(C_RETIRED); end
      12'hB82: begin s.kind = K_COUNT; s.idx = IDX_W'(C_RETIRED); s.hi = 1'b1; end
      12'h301: begin s.kind = K_CONST; s.idx = IDX_W'(Q_ISA);  end
      12'hF12: begin s.kind = K_CONST; s.idx = IDX_W'(Q_ARCH); end
      12'hF13: begin s.kind = K_CONST; s.idx = IDX_W'(Q_IMPL); end
      12'hF14: begin s.kind = K_CONST; s.idx = IDX_W'(Q_HART); end
      12'h343, 12'h344: begin s.kind = K_CONST; s.idx = IDX_W'(Q_ZERO); end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    priv,
  output sel_t          sel,
  output logic          legal
);
  logic in_range;
  logic priv_ok;

  assign in_range = ((addr >> CSR_AW) == '0);
  assign priv_ok  = (addr[9:8] <= priv);
  assign sel      = csr_decode(addr[CSR_AW-1:0]);
  assign legal    = in_range && priv_ok && (sel.kind != K_NONE);
endmodule

// File: rtl/mcsr_plain_regs.sv
module mcsr_plain_regs
  import mcsr_pkg::*;
#(
  parameter int N = NPLAIN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           we,
  input  word_t                  wdata,
  output logic [N-1:0][XLEN-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam word_t MASK = plain_mask(i);
    always_ff @(posedge clk) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= wdata & MASK;
    end
  end
endmodule

// File: rtl/mcsr_counter64.sv
module mcsr_counter64
  import mcsr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int FULL = 2 * W;
  logic [FULL-1:0] nxt;

  assign nxt = {hi, lo} + {{(FULL-1){1'b0}}, inc};

  // a software write to a half replaces the incremented value of that half
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wdata : nxt[W-1:0];
      hi <= wr_hi ? wdata : nxt[FULL-1:W];
    end
  end
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [31:0] ISA_ID  = 32'h4000_1104,
  parameter logic [31:0] ARCH_ID = 32'h0000_0000,
  parameter logic [31:0] IMPL_ID = 32'h0000_0001,
  parameter logic [31:0] HART_ID = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [1:0]    cur_priv,
  input  logic          retire,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_illegal
);
  localparam int CW = (NCNT > 1) ? $clog2(NCNT) : 1;

  sel_t    sel;
  logic    legal;
  csr_op_e op;
  word_t   old_val;
  word_t   new_val;
  word_t   const_val;
  logic    do_wr;

  logic [NPLAIN-1:0][XLEN-1:0] plain_q;
  logic [NPLAIN-1:0]           plain_we;
  logic [NCNT-1:0][XLEN-1:0]   cnt_lo;
  logic [NCNT-1:0][XLEN-1:0]   cnt_hi;

  mcsr_decode #(.AW(AW)) u_dec (
    .addr  (req_addr),
    .priv  (cur_priv),
    .sel   (sel),
    .legal (legal)
  );

  assign op = csr_op_e'(req_op);

  always_comb begin
    case (sel.idx)
      IDX_W'(Q_ISA):  const_val = ISA_ID;
      IDX_W'(Q_ARCH): const_val = ARCH_ID;
      IDX_W'(Q_IMPL): const_val = IMPL_ID;
      IDX_W'(Q_HART): const_val = HART_ID;
      default:        const_val = '0;
    endcase
  end

  // old value: what a read sees and what set/clear start from
  always_comb begin
    case (sel.kind)
      K_PLAIN: old_val = plain_q[sel.idx];
      K_COUNT: old_val = sel.hi ? cnt_hi[sel.idx[CW-1:0]] : cnt_lo[sel.idx[CW-1:0]];
      K_CONST: old_val = const_val;
      default: old_val = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_WRITE: new_val = req_wdata;
      OP_SET:   new_val = old_val | req_wdata;
      OP_CLEAR: new_val = old_val & ~req_wdata;
      default:  new_val = old_val;
    endcase
  end

  assign do_wr       = req_valid && legal && (op != OP_READ);
  assign rsp_illegal = req_valid && !legal;
  assign rsp_rdata   = (req_valid && legal) ? old_val : '0;

  for (genvar i = 0; i < NPLAIN; i++) begin : g_pwe
    assign plain_we[i] = do_wr && (sel.kind == K_PLAIN) && (sel.idx == IDX_W'(i));
  end

  mcsr_plain_regs #(.N(NPLAIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (plain_we),
    .wdata (new_val),
    .q     (plain_q)
  );

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    localparam int INH = (c == C_CYCLE) ? INH_CYC_BIT : INH_RET_BIT;
    logic event_hit;
    logic wr_here;
    assign event_hit = (c == C_CYCLE) ? 1'b1 : retire;
    assign wr_here   = do_wr && (sel.kind == K_COUNT) && (sel.idx == IDX_W'(c));

    mcsr_counter64 #(.W(XLEN)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (event_hit && !plain_q[P_INHIBIT][INH]),
      .wr_lo (wr_here && !sel.hi),
      .wr_hi (wr_here && sel.hi),
      .wdata (new_val),
      .lo    (cnt_lo[c]),
      .hi    (cnt_hi[c])
    );
  end
endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk
  import mcsr_pkg::*;
#(
  parameter int AW = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [1:0]                  req_op,
  input logic [AW-1:0]               req_addr,
  input logic [1:0]                  cur_priv,
  input logic                        retire,
  input logic                        rsp_illegal,
  input logic [NPLAIN-1:0][XLEN-1:0] plain_q,
  input logic [2*XLEN-1:0]           cyc,
  input logic [2*XLEN-1:0]           ret
);
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_addr >> CSR_AW) != '0)) |-> rsp_illegal); // R1

  AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[9:8] > cur_priv)) |-> rsp_illegal); // R1

  AST_REJECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_illegal) |=> (plain_q == $past(plain_q))); // R2

  AST_TVEC_BIT1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_illegal && (req_op != 2'd0) && (req_addr == AW'(12'h305)))
      |=> (plain_q[P_TVEC][1] == 1'b0)); // R4

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !plain_q[P_INHIBIT][INH_CYC_BIT]) |=> (cyc == $past(cyc) + 64'd1)); // R6

  AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !retire) |=> $stable(ret)); // R7
endmodule

bind mcsr_file mcsr_file_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .cur_priv    (cur_priv),
  .retire      (retire),
  .rsp_illegal (rsp_illegal),
  .plain_q     (plain_q),
  .cyc         ({cnt_hi[0], cnt_lo[0]}),
  .ret         ({cnt_hi[1], cnt_lo[1]})
);

// File: tb/mcsr_file_bench.sv
`timescale 1ns/1ps
module mcsr_file_bench;
  localparam logic [31:0] ISA_V  = 32'h4000_1104;
  localparam logic [31:0] ARCH_V = 32'h0000_0023;
  localparam logic [31:0] IMPL_V = 32'h0000_0002;
  localparam logic [31:0] HART_V = 32'h0000_0005;

  logic        clk = 1'b0;
  logic        rst_n, req_valid, retire, rsp_illegal;
  logic [1:0]  req_op, cur_priv;
  logic [15:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;

  always #2 clk = ~clk;

  mcsr_file #(.AW(16), .ISA_ID(ISA_V), .ARCH_ID(ARCH_V), .IMPL_ID(IMPL_V), .HART_ID(HART_V)) u_mcsr_file (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .cur_priv(cur_priv), .retire(retire),
    .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] got_rd;
  logic        got_ill;
  logic [31:0] v1, v2;

  localparam logic [15:0] PADDR [7] = '{16'h300, 16'h304, 16'h305, 16'h320, 16'h340, 16'h341, 16'h342};
  localparam logic [31:0] PMASK [7] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'h0000_0007,
                                        32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h8000_000F};

  function automatic bit known(input int a);
    case (a)
      'h300, 'h301, 'h304, 'h305, 'h320, 'h340, 'h341, 'h342, 'h343, 'h344,
      'hB00, 'hB02, 'hB80, 'hB82, 'hF12, 'hF13, 'hF14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d, input logic [1:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; cur_priv = p; retire = 1'b0;
    #1;
    got_rd  = rsp_rdata;
    got_ill = rsp_illegal;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    access(2'd1, a, d, 2'd3);
  endtask

  task automatic rd(input logic [15:0] a);
    access(2'd0, a, 32'h0, 2'd3);
  endtask

  task automatic idle(input int n, input logic r);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0; retire = r;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0;
    req_wdata = '0; cur_priv = 2'd3; retire = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    for (int i = 0; i < 7; i++) begin
      rd(PADDR[i]);
      check("R9 writable reg after reset", got_rd, 32'h0);
    end
    rd(16'hB02); check("R9 retire low after reset", got_rd, 32'h0);
    rd(16'hB82); check("R9 retire high after reset", got_rd, 32'h0);
    rd(16'hB80); check("R9 cycle high after reset", got_rd, 32'h0);

    // R1, R10: every register number at every privilege level
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 4096; a++) begin
        bit exp_ill;
        exp_ill = !(known(a) && (((a >> 8) & 3) <= p));
        access(2'd0, 16'(a), 32'h0, 2'(p));
        check("R1/R10 illegal flag", {31'h0, got_ill}, {31'h0, exp_ill});
        if (exp_ill) check("R1 rdata zero when illegal", got_rd, 32'h0);
      end
    end
    for (int h = 1; h < 16; h++) begin
      access(2'd0, 16'((h << 12) | 'h340), 32'h0, 2'd3);
      check("R1 address above 4095", {31'h0, got_ill}, 32'h1);
    end

    // R4, R10: masks on every writable register
    for (int i = 0; i < 7; i++) begin
      wr(PADDR[i], 32'hFFFF_FFFF);
      rd(PADDR[i]);
      check("R4/R10 masked all-ones", got_rd, PMASK[i]);
      wr(PADDR[i], 32'h0);
      rd(PADDR[i]);
      check("R4 write zero", got_rd, 32'h0);
    end

    // R3: set and clear, old value returned
    wr(16'h340, 32'h1234_5678);
    check("R3 write returns old", got_rd, 32'h0);
    access(2'd2, 16'h340, 32'h0F0F_0000, 2'd3);
    check("R3 set returns old", got_rd, 32'h1234_5678);
    rd(16'h340);
    check("R3 set result", got_rd, 32'h1234_5678 | 32'h0F0F_0000);
    access(2'd3, 16'h340, 32'h00FF_00FF, 2'd3);
    rd(16'h340);
    check("R3 clear result", got_rd, (32'h1234_5678 | 32'h0F0F_0000) & ~32'h00FF_00FF);
    wr(16'h341, 32'h0);
    access(2'd2, 16'h341, 32'h0000_0005, 2'd3);
    rd(16'h341);
    check("R3/R4 set then mask", got_rd, 32'h0000_0004);
    wr(16'h342, 32'hFFFF_FFFF);
    access(2'd3, 16'h342, 32'h0000_0003, 2'd3);
    rd(16'h342);
    check("R3 clear on cause", got_rd, 32'h8000_000C);

    // R2: rejected accesses leave state alone
    wr(16'h340, 32'hA5A5_A5A5);
    access(2'd1, 16'h340, 32'h0, 2'd1);
    check("R2 low privilege flagged", {31'h0, got_ill}, 32'h1);
    check("R2 rdata zero", got_rd, 32'h0);
    access(2'd2, 16'h340, 32'hFFFF_FFFF, 2'd2);
    access(2'd1, 16'h1340, 32'h0, 2'd3);
    access(2'd1, 16'h3FF, 32'h0, 2'd3);
    check("R2 unknown address flagged", {31'h0, got_ill}, 32'h1);
    rd(16'h340);
    check("R2 scratch unchanged", got_rd, 32'hA5A5_A5A5);

    // R5: read-only words
    wr(16'hF14, 32'hDEAD_BEEF); check("R5 hart id write accepted", {31'h0, got_ill}, 32'h0);
    wr(16'h301, 32'h0);         check("R5 isa write accepted", {31'h0, got_ill}, 32'h0);
    wr(16'h344, 32'hFFFF_FFFF);
    wr(16'h343, 32'hFFFF_FFFF);
    rd(16'hF14); check("R5 hart id", got_rd, HART_V);
    rd(16'h301); check("R5 isa word", got_rd, ISA_V);
    rd(16'hF12); check("R5 arch id", got_rd, ARCH_V);
    rd(16'hF13); check("R5 impl id", got_rd, IMPL_V);
    rd(16'h344); check("R5 zero word 0x344", got_rd, 32'h0);
    rd(16'h343); check("R5 zero word 0x343", got_rd, 32'h0);

    // R6: back-to-back reads one cycle apart
    rd(16'hB00); v1 = got_rd;
    rd(16'hB00); v2 = got_rd;
    check("R6 cycle step", v2, v1 + 32'd1);

    // R8: write wins over increment
    wr(16'hB00, 32'd100);
    rd(16'hB00); check("R8 written low half", got_rd, 32'd100);
    wr(16'hB00, 32'h0);
    idle(8, 1'b0);
    rd(16'hB00); check("R8 zero then eight cycles", got_rd, 32'd8);
    wr(16'hB80, 32'd7);
    rd(16'hB80); check("R8 written high half", got_rd, 32'd7);

    // R6, R10: inhibit freezes, carry into high half on release
    wr(16'h320, 32'h1);
    wr(16'hB80, 32'd5);
    wr(16'hB00, 32'hFFFF_FFFF);
    idle(3, 1'b0);
    rd(16'hB00); check("R6 inhibited low holds", got_rd, 32'hFFFF_FFFF);
    rd(16'hB80); check("R6 inhibited high holds", got_rd, 32'd5);
    wr(16'h320, 32'h0);
    idle(1, 1'b0);
    rd(16'hB00); check("R6 low wraps", got_rd, 32'h0);
    rd(16'hB80); check("R6 carry into high", got_rd, 32'd6);

    // R7: retire counter
    wr(16'hB02, 32'h0);
    idle(5, 1'b1);
    rd(16'hB02); check("R7 five retires", got_rd, 32'd5);
    idle(3, 1'b0);
    rd(16'hB02); check("R7 no retire no change", got_rd, 32'd5);
    wr(16'h320, 32'h4);
    idle(4, 1'b1);
    rd(16'hB02); check("R7 inhibited", got_rd, 32'd5);
    wr(16'h320, 32'h0);
    idle(2, 1'b1);
    rd(16'hB02); check("R7 resumes", got_rd, 32'd7);
    wr(16'hB82, 32'd3);
    rd(16'hB82); check("R7 high half write", got_rd, 32'd3);

    idle(1, 1'b0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule